// File: doc/BRIEF.md
# Pulse Timestamp Buffer

This block keeps a free-running time of day and records the time at which each detected pulse arrives. The time is split into a 40-bit seconds count and a 28-bit sub-second cycle count. The cycle count wraps once per second of clock time, and each wrap adds one to the seconds count. Software can set the seconds count one word at a time. Setting either word restarts the cycle count from zero.

Each pulse strobe writes the current time into a circular store of power-of-two depth. Software sees the oldest unread entry as three read-only fields: seconds low word, seconds high byte and cycle count. Software reads the fields in any order. It must read the cycle field last, because that read is signalled to the block by a strobe that retires the entry. After that strobe the fields show the next entry.

When the store is full, a new pulse evicts the oldest entry. The store therefore always holds the most recent stamps.

Top module: `pulse_tag_store`

## Requirements
- R1: After reset the store is empty (`empty_o`=1, `full_o`=0), every tag field reads 0, and the live time is 0 seconds and 0 cycles.
- R2: Without a load, `now_cyc_o` rises by one on every clock. When it equals CLK_HZ-1, the next value is 0 and `now_sec_o` rises by one, wrapping modulo 2^40. At all other times `now_sec_o` holds its value.
- R3: `set_lo_i` writes `set_data_i` into seconds bits 31:0. `set_hi_i` writes `set_data_i[7:0]` into seconds bits 39:32. Both strobes in one cycle write both parts. A word that is not written keeps its value. On the cycle after any load, `now_cyc_o` is 0, and no seconds increment happens on the load cycle.
- R4: A cycle with `pulse_i`=1 stores the `now_sec_o`/`now_cyc_o` values visible in that same cycle.
- R5: The tag fields show the oldest unread entry. A `tag_done_i` strobe while the store is not empty retires that entry, and the fields show the next entry one cycle later. While the store is empty, the tag fields read 0.
- R6: A `tag_done_i` strobe while the store is empty has no effect on the store.
- R7: A pulse while the store holds DEPTH entries drops the oldest entry. The store stays full and holds the newest DEPTH stamps in arrival order.
- R8: A pulse and a `tag_done_i` strobe in the same cycle on a non-empty store retire the oldest entry and append the new stamp, leaving the occupancy unchanged. On an empty store, the same pair stores the stamp.
- R9: `empty_o` is 1 exactly when the store holds 0 entries. `full_o` is 1 exactly when it holds DEPTH entries.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock; cycle count runs on it |
| rst_n | input | 1 | Active-low synchronous reset |
| pulse_i | input | 1 | One-cycle strobe per detected pulse |
| set_lo_i | input | 1 | Load seconds bits 31:0 |
| set_hi_i | input | 1 | Load seconds bits 39:32 |
| set_data_i | input | 32 | Load value |
| tag_done_i | input | 1 | Strobe for the read of the last tag field; retires the entry |
| now_sec_o | output | 40 | Live seconds count |
| now_cyc_o | output | 28 | Live cycle count |
| tag_sec_lo_o | output | 32 | Oldest entry, seconds bits 31:0 |
| tag_sec_hi_o | output | 8 | Oldest entry, seconds bits 39:32 |
| tag_cyc_o | output | 28 | Oldest entry, cycle count |
| empty_o | output | 1 | Store holds no entries |
| full_o | output | 1 | Store holds DEPTH entries |

## Verification
A read pointer that drifts shows up on the first retire strobe after the fault: the tag fields present a stamp out of order, or a stale stamp. A miscounted occupancy shows on `empty_o` or `full_o` within one cycle of the wrong update. It also produces missing or repeated entries during the next drain. A cycle counter with the wrong wrap point shows within CLK_HZ cycles, as a seconds step at the wrong time. The small configuration keeps that window to a few clocks, and every fill level from 0 to DEPTH gets a combined push and retire.

// File: rtl/tsb_pkg.sv
package tsb_pkg;
  localparam int SEC_W   = 40;
  localparam int CYC_W   = 28;
  localparam int LO_W    = 32;
  localparam int HI_W    = SEC_W - LO_W;
  localparam int STAMP_W = SEC_W + CYC_W;

  typedef struct packed {
    logic [SEC_W-1:0] sec;
    logic [CYC_W-1:0] cyc;
  } stamp_t;

  // advance the time by one clock, wrapping the cycle count at last
  function automatic stamp_t tick(stamp_t cur, logic [CYC_W-1:0] last);
    stamp_t nx;
    if (cur.cyc == last) begin
      nx.cyc = '0;
      nx.sec = cur.sec + SEC_W'(1);
    end else begin
      nx.cyc = cur.cyc + CYC_W'(1);
      nx.sec = cur.sec;
    end
    return nx;
  endfunction

  // replace the selected seconds words by the load value
  function automatic logic [SEC_W-1:0] splice_sec(logic [SEC_W-1:0] cur,
                                                  logic [LO_W-1:0]  data,
                                                  logic             wr_lo,
                                                  logic             wr_hi);
    logic [SEC_W-1:0] r;
    r = cur;
    if (wr_lo) r[LO_W-1:0]     = data;
    if (wr_hi) r[SEC_W-1:LO_W] = data[HI_W-1:0];
    return r;
  endfunction

  // occupancy after one cycle of push / pop / drop
  function automatic int unsigned occ_next(int unsigned cur, logic push,
                                           logic pop, logic drop);
    return cur + int'(push) - int'(pop) - int'(drop);
  endfunction
endpackage

// File: rtl/tsb_timebase.sv
module tsb_timebase
  import tsb_pkg::*;
#(
  parameter int unsigned CLK_HZ = 20_000_000
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic            ld_lo,
  input  logic            ld_hi,
  input  logic [LO_W-1:0] ld_data,
  output stamp_t          now,
  output logic            roll_evt
);
  localparam logic [CYC_W-1:0] LAST = CYC_W'(CLK_HZ - 1);

  logic ld_any;
  assign ld_any   = ld_lo | ld_hi;
  assign roll_evt = !ld_any && (now.cyc == LAST);

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      now <= '0;
    end else if (ld_any) begin
      now.sec <= splice_sec(now.sec, ld_data, ld_lo, ld_hi);
      now.cyc <= '0;
    end else begin
      now <= tick(now, LAST);
    end
  end
endmodule

// File: rtl/tsb_ptr_ctrl.sv
module tsb_ptr_ctrl
  import tsb_pkg::*;
#(
  parameter int unsigned DEPTH = 16,
  localparam int AW = $clog2(DEPTH),
  localparam int CW = AW + 1
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          push,
  input  logic          rd_req,
  output logic [AW-1:0] wr_ptr,
  output logic [AW-1:0] rd_ptr,
  output logic          empty,
  output logic          full,
  output logic          pop_evt,
  output logic          drop_evt
);
  logic [CW-1:0] count;
  logic [CW-1:0] count_nx;

  assign empty    = (count == '0);
  assign full     = (count == CW'(DEPTH));
  assign pop_evt  = rd_req && !empty;
  assign drop_evt = push && full && !pop_evt;
  assign count_nx = CW'(occ_next(int'(count), push, pop_evt, drop_evt));

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      wr_ptr <= '0;
      rd_ptr <= '0;
      count  <= '0;
    end else begin
      if (push)                wr_ptr <= wr_ptr + AW'(1);
      if (pop_evt || drop_evt) rd_ptr <= rd_ptr + AW'(1);
      count <= count_nx;
    end
  end
endmodule

// File: rtl/tsb_store.sv
module tsb_store
  import tsb_pkg::*;
#(
  parameter int unsigned DEPTH = 16,
  localparam int AW = $clog2(DEPTH)
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          wr_en,
  input  logic [AW-1:0] wr_ptr,
  input  stamp_t        wr_data,
  input  logic [AW-1:0] rd_ptr,
  output stamp_t        rd_data
);
  logic [DEPTH-1:0][STAMP_W-1:0] rows;

  for (genvar i = 0; i < DEPTH; i++) begin : g_row
    stamp_t q;
    always_ff @(posedge clk) begin
      if (!rst_n)                              q <= '0;
      else if (wr_en && (wr_ptr == AW'(i)))    q <= wr_data;
    end
    assign rows[i] = q;
  end

  assign rd_data = stamp_t'(rows[rd_ptr]);
endmodule

// File: rtl/pulse_tag_store.sv
module pulse_tag_store
  import tsb_pkg::*;
#(
  parameter int unsigned DEPTH  = 16,
  parameter int unsigned CLK_HZ = 20_000_000
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              pulse_i,
  input  logic              set_lo_i,
  input  logic              set_hi_i,
  input  logic [31:0]       set_data_i,
  input  logic              tag_done_i,
  output logic [39:0]       now_sec_o,
  output logic [27:0]       now_cyc_o,
  output logic [31:0]       tag_sec_lo_o,
  output logic [7:0]        tag_sec_hi_o,
  output logic [27:0]       tag_cyc_o,
  output logic              empty_o,
  output logic              full_o
);
  localparam int AW = $clog2(DEPTH);

  stamp_t        now;
  stamp_t        head;
  logic [AW-1:0] wr_ptr;
  logic [AW-1:0] rd_ptr;
  logic          roll_evt;
  logic          pop_evt;
  logic          drop_evt;
  logic          empty;
  logic          full;

  tsb_timebase #(.CLK_HZ(CLK_HZ)) u_time (
    .clk      (clk),
    .rst_n    (rst_n),
    .ld_lo    (set_lo_i),
    .ld_hi    (set_hi_i),
    .ld_data  (set_data_i),
    .now      (now),
    .roll_evt (roll_evt)
  );

  tsb_ptr_ctrl #(.DEPTH(DEPTH)) u_ptr (
    .clk      (clk),
    .rst_n    (rst_n),
    .push     (pulse_i),
    .rd_req   (tag_done_i),
    .wr_ptr   (wr_ptr),
    .rd_ptr   (rd_ptr),
    .empty    (empty),
    .full     (full),
    .pop_evt  (pop_evt),
    .drop_evt (drop_evt)
  );

  tsb_store #(.DEPTH(DEPTH)) u_store (
    .clk     (clk),
    .rst_n   (rst_n),
    .wr_en   (pulse_i),
    .wr_ptr  (wr_ptr),
    .wr_data (now),
    .rd_ptr  (rd_ptr),
    .rd_data (head)
  );

  assign now_sec_o    = now.sec;
  assign now_cyc_o    = now.cyc;
  assign tag_sec_lo_o = empty ? '0 : head.sec[LO_W-1:0];
  assign tag_sec_hi_o = empty ? '0 : head.sec[SEC_W-1:LO_W];
  assign tag_cyc_o    = empty ? '0 : head.cyc;
  assign empty_o      = empty;
  assign full_o       = full;
endmodule

// File: rtl/tsb_checker.sv
module tsb_checker #(
  parameter int unsigned CLK_HZ = 20_000_000
) (
  input logic        clk,
  input logic        rst_n,
  input logic        pulse_i,
  input logic        set_lo_i,
  input logic        set_hi_i,
  input logic        tag_done_i,
  input logic [39:0] now_sec_o,
  input logic [27:0] now_cyc_o,
  input logic [31:0] tag_sec_lo_o,
  input logic [27:0] tag_cyc_o,
  input logic        empty_o,
  input logic        full_o,
  input logic        roll_evt,
  input logic        drop_evt
);
  localparam logic [27:0] LAST = 28'(CLK_HZ - 1);

  // R2
  cyc_step_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (!set_lo_i && !set_hi_i && now_cyc_o != LAST) |=>
      (now_cyc_o == $past(now_cyc_o) + 28'd1) && $stable(now_sec_o));

  // R2
  sec_roll_chk: assert property (@(posedge clk) disable iff (!rst_n)
    roll_evt |=> (now_cyc_o == 28'd0) && (now_sec_o == $past(now_sec_o) + 40'd1));

  // R3
  load_clear_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (set_lo_i || set_hi_i) |=> (now_cyc_o == 28'd0));

  // R4
  first_capture_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (empty_o && pulse_i) |=>
      (!empty_o && tag_sec_lo_o == $past(now_sec_o[31:0]) && tag_cyc_o == $past(now_cyc_o)));

  // R6
  empty_read_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (empty_o && tag_done_i && !pulse_i) |=> empty_o);

  // R7
  overwrite_full_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (full_o && pulse_i) |=> full_o);

  // R7
  drop_when_full_chk: assert property (@(posedge clk) disable iff (!rst_n)
    drop_evt |-> full_o);

  // R8
  push_pop_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (!empty_o && pulse_i && tag_done_i) |=> ($stable(empty_o) && $stable(full_o)));

  // R9
  flag_excl_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !(empty_o && full_o));
endmodule

bind pulse_tag_store tsb_checker #(.CLK_HZ(CLK_HZ)) u_chk (
  .clk          (clk),
  .rst_n        (rst_n),
  .pulse_i      (pulse_i),
  .set_lo_i     (set_lo_i),
  .set_hi_i     (set_hi_i),
  .tag_done_i   (tag_done_i),
  .now_sec_o    (now_sec_o),
  .now_cyc_o    (now_cyc_o),
  .tag_sec_lo_o (tag_sec_lo_o),
  .tag_cyc_o    (tag_cyc_o),
  .empty_o      (empty_o),
  .full_o       (full_o),
  .roll_evt     (roll_evt),
  .drop_evt     (drop_evt)
);

// File: tb/test_pulse_tag_store.sv
`timescale 1ns/1ps
module test_pulse_tag_store;
  localparam int unsigned DEPTH = 4;
  localparam int unsigned HZ    = 7;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        pulse_i = 1'b0;
  logic        set_lo_i = 1'b0;
  logic        set_hi_i = 1'b0;
  logic [31:0] set_data_i = '0;
  logic        tag_done_i = 1'b0;
  logic [39:0] now_sec_o;
  logic [27:0] now_cyc_o;
  logic [31:0] tag_sec_lo_o;
  logic [7:0]  tag_sec_hi_o;
  logic [27:0] tag_cyc_o;
  logic        empty_o;
  logic        full_o;

  int checks = 0;
  int errors = 0;

  // expected state: time = base + ticks, queue of {sec, cyc}
  longint unsigned base_sec = 0;
  longint unsigned ticks = 0;
  logic [67:0] mq[$];

  always #2.5 clk = ~clk;

  pulse_tag_store #(.DEPTH(DEPTH), .CLK_HZ(HZ)) i_pulse_tag_store (.*);

  function automatic logic [39:0] exp_sec();
    return 40'(base_sec + ticks / HZ);
  endfunction

  function automatic logic [27:0] exp_cyc();
    return 28'(ticks % HZ);
  endfunction

  task automatic chk(input string req, input string what,
                     input longint unsigned act, input longint unsigned exp);
    checks++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s %s: actual %h expected %h", req, what, act, exp);
    end
  endtask

  task automatic check_all(input string req);
    logic [67:0] hd;
    chk(req, "now_sec", now_sec_o, exp_sec());
    chk(req, "now_cyc", now_cyc_o, exp_cyc());
    chk(req, "empty", empty_o, (mq.size() == 0) ? 1 : 0);
    chk(req, "full", full_o, (mq.size() == DEPTH) ? 1 : 0);
    hd = (mq.size() == 0) ? '0 : mq[0];
    chk(req, "tag_sec_lo", tag_sec_lo_o, hd[59:28]);
    chk(req, "tag_sec_hi", tag_sec_hi_o, hd[67:60]);
    chk(req, "tag_cyc", tag_cyc_o, hd[27:0]);
  endtask

  // drive at negedge, clock once, update model, compare at next negedge
  task automatic step(input string req, input logic p, input logic lo,
                      input logic hi, input logic [31:0] d, input logic rd);
    logic [67:0] cap;
    logic [39:0] s;
    pulse_i = p; set_lo_i = lo; set_hi_i = hi; set_data_i = d; tag_done_i = rd;
    cap = {exp_sec(), exp_cyc()};
    @(posedge clk);
    if (rd && mq.size() > 0) void'(mq.pop_front());
    if (p) begin
      if (mq.size() == DEPTH) void'(mq.pop_front());
      mq.push_back(cap);
    end
    if (lo || hi) begin
      s = exp_sec();
      if (lo) s[31:0]  = d;
      if (hi) s[39:32] = d[7:0];
      base_sec = longint'(s);
      ticks = 0;
    end else begin
      ticks++;
    end
    @(negedge clk);
    pulse_i = 0; set_lo_i = 0; set_hi_i = 0; tag_done_i = 0;
    check_all(req);
  endtask

  task automatic idle(input string req, input int n);
    for (int i = 0; i < n; i++) step(req, 0, 0, 0, '0, 0);
  endtask

  task automatic drain(input string req);
    while (mq.size() > 0) step(req, 0, 0, 0, '0, 1);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    check_all("R1");
    rst_n = 1'b1;
    // R2: free run through several wraps
    idle("R2", 3 * HZ + 2);
    // R3: low word load and carry past the low word
    step("R3", 0, 1, 0, 32'hFFFF_FFFE, 0);
    idle("R3", 2 * HZ + 1);
    // R3: high word alone keeps the low word
    step("R3", 0, 0, 1, 32'h0000_00A5, 0);
    idle("R3", 3);
    // R3 and R2: both words, then wrap modulo 2^40
    step("R3", 0, 1, 1, 32'hFFFF_FFFF, 0);
    idle("R2", HZ + 2);
    // R3: load in the middle of a second, mid-count restart
    idle("R3", 3);
    step("R3", 0, 1, 0, 32'h0000_1234, 0);
    idle("R3", 2);
    // R4 R5 R9: irregular fill then ordered readout
    for (int i = 0; i < DEPTH; i++) begin
      step("R4", 1, 0, 0, '0, 0);
      idle("R9", i % 3);
    end
    for (int i = 0; i < DEPTH; i++) begin
      step("R5", 0, 0, 0, '0, 1);
      idle("R5", 1);
    end
    // R6: retire strobes on an empty store, then one capture
    step("R6", 0, 0, 0, '0, 1);
    step("R6", 0, 0, 0, '0, 1);
    idle("R6", 1);
    step("R6", 1, 0, 0, '0, 0);
    drain("R6");
    // R7: overflow by three, newest kept
    for (int i = 0; i < DEPTH + 3; i++) step("R7", 1, 0, 0, '0, 0);
    idle("R7", 2);
    drain("R7");
    // R8: combined push and retire at every fill level
    for (int f = 0; f <= DEPTH; f++) begin
      for (int i = 0; i < f; i++) step("R8", 1, 0, 0, '0, 0);
      step("R8", 1, 0, 0, '0, 1);
      step("R8", 1, 0, 0, '0, 1);
      drain("R8");
    end
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    repeat (100000) @(posedge clk);
    checks++;
    errors++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule